// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction Translation Buffer

This block translates instruction fetch addresses from effective to physical form through a small direct-mapped table. Each slot holds a valid bit, a tag, a real page number and a privilege flag. The slot for an address is picked by folding three 6-bit fields of the effective page number together with XOR. The fold spreads neighbouring pages and aliased regions across the table, where a plain low-bit index would not.

Entries are written through a load port. A single slot can be invalidated by page number without a tag check, and the whole table can be flushed in one cycle. A lookup is combinational from the table registers. When virtual mode is on, a miss raises fetch-failed. A hit on a privileged entry made by a user-mode fetch also raises fetch-failed. When virtual mode is off, the address passes straight through.

The lookup path has no valid/ready handshake. The result is a pure function of the present inputs and the table contents, so it never applies back-pressure. A caller that stalls simply holds its address. Updates take effect at the next rising clock edge.

Top module: `itlb_top`

## Requirements
- R1: The slot index is ea[17:12] ^ ea[23:18] ^ ea[29:24] with the default 64 entries. The load and invalidate ports fold bits [5:0], [11:6] and [17:12] of their page-number inputs in the same way.
- R2: `hit` needs `virt_mode`=1, the slot's valid bit and an exact match of all of ea[63:12] against the stored tag. An address that lands in the same slot with a different tag misses.
- R3: On a hit, `pa` = {stored real page number, ea[11:0]}. The page number is written from `ld_rpn`.
- R4: In virtual mode, a miss gives `hit`=0, `fetch_failed`=1 and `pa`=0.
- R5: `ld_priv` carries the privilege bit of the entry (bit 3 of the page table entry). If the stored flag is 1 and `priv_mode`=0 (user fetch), `fetch_failed`=1 while `hit` stays 1. With `priv_mode`=1, the same entry gives `fetch_failed`=0.
- R6: With `virt_mode`=0: `pa` = ea[55:0], `hit`=0 and `fetch_failed`=0, whatever the table holds.
- R7: `inv_en` clears the valid bit of the slot that `inv_vpn` hashes to, whatever that slot's tag is.
- R8: `inv_all` clears every valid bit at the next edge. A load in the same cycle is dropped.
- R9: Reset (`rst_n`=0) clears every valid bit.
- R10: A load is visible from the next cycle. A lookup in the same cycle as a load to the same slot returns the old contents. A load and a single-slot invalidate to the same slot leave the slot valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea | input | 64 | Fetch effective address |
| virt_mode | input | 1 | 1: translate through the table |
| priv_mode | input | 1 | 1: privileged fetch, 0: user fetch |
| ld_en | input | 1 | Write an entry |
| ld_epn | input | 52 | Effective page number (ea[63:12]) of the entry loaded |
| ld_rpn | input | 44 | Real page number of the entry loaded |
| ld_priv | input | 1 | Privilege bit of the entry loaded |
| inv_en | input | 1 | Invalidate one slot |
| inv_all | input | 1 | Invalidate every slot |
| inv_vpn | input | 18 | Page-number bits [17:0] that select the slot to invalidate |
| pa | output | 56 | Physical address |
| hit | output | 1 | Valid translation found |
| fetch_failed | output | 1 | Translation miss or privilege fault |

## Verification
The assertions check these behaviours on every cycle:
- real-mode pass-through;
- that a hit always matches the stored valid bit and tag;
- the user-fetch fault on privileged entries;
- that a load, invalidate or flush reaches the valid bits one cycle later.

Only the bench scenarios can show that the fold picks the intended slot, since no property can show that two distinct addresses collide or separate. The same holds for same-cycle old-data reads, for the load-over-invalidate ordering, and for reset emptying the table. A behavioural model of the table is compared against all outputs on every clock, through directed cases and a random mix of traffic.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0,
    FC_MISS = 2'd1,
    FC_PRIV = 2'd2
  } fault_cause_e;
endpackage

// File: rtl/itlb_hash.sv
module itlb_hash #(
  parameter int IDX_W = 6,
  parameter int NFOLD = 3,
  localparam int HASH_W = IDX_W * NFOLD
) (
  input  logic [HASH_W-1:0] vpn_lo,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] part [NFOLD];

  for (genvar k = 0; k < NFOLD; k++) begin : g_part
    assign part[k] = vpn_lo[k*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < NFOLD; k++) idx = idx ^ part[k];
  end
endmodule

// File: rtl/itlb_store.sv
module itlb_store #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 52,
  parameter int RPN_W = 44,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [RPN_W-1:0] ld_rpn,
  input  logic             ld_priv,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             inv_all,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  output logic [RPN_W-1:0] rd_rpn,
  output logic             rd_priv
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [RPN_W-1:0]   rpn_q  [ENTRIES];
  logic               priv_q [ENTRIES];
  logic               wr_ok;

  assign wr_ok = ld_en && !inv_all;

  // Valid bits: flush beats everything; a load beats a single invalidate.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (inv_all) begin
      vld_q <= '0;
    end else begin
      if (inv_en) vld_q[inv_idx] <= 1'b0;
      if (ld_en)  vld_q[ld_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      tag_q[ld_idx]  <= ld_tag;
      rpn_q[ld_idx]  <= ld_rpn;
      priv_q[ld_idx] <= ld_priv;
    end
  end

  assign rd_vld  = vld_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_rpn  = rpn_q[rd_idx];
  assign rd_priv = priv_q[rd_idx];

  // R8: a flush leaves no valid slot behind
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));

  // R10: a load is valid and carries its tag from the next cycle
  a_r10_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (vld_q[$past(ld_idx)] && tag_q[$past(ld_idx)] == $past(ld_tag)));

  // R7: a single invalidate with no competing load clears the slot
  a_r7_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !inv_all && !(ld_en && ld_idx == inv_idx)) |=> !vld_q[$past(inv_idx)]);
endmodule

// File: rtl/itlb_check.sv
module itlb_check
  import itlb_pkg::*;
#(
  parameter int EA_W    = 64,
  parameter int PA_W    = 56,
  parameter int PG_BITS = 12,
  localparam int TAG_W = EA_W - PG_BITS,
  localparam int RPN_W = PA_W - PG_BITS
) (
  input  logic [EA_W-1:0]  ea,
  input  logic             virt_mode,
  input  logic             priv_mode,
  input  logic             rd_vld,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [RPN_W-1:0] rd_rpn,
  input  logic             rd_priv,
  output logic [PA_W-1:0]  pa,
  output logic             hit,
  output logic             fetch_failed
);
  fault_cause_e cause;
  logic         match;

  assign match = rd_vld && (rd_tag == ea[EA_W-1:PG_BITS]);

  always_comb begin
    if (!virt_mode)                   cause = FC_NONE;
    else if (!match)                  cause = FC_MISS;
    else if (rd_priv && !priv_mode)   cause = FC_PRIV;
    else                              cause = FC_NONE;
  end

  always_comb begin
    hit          = virt_mode && match;
    fetch_failed = (cause != FC_NONE);
    if (!virt_mode)  pa = ea[PA_W-1:0];
    else if (match)  pa = {rd_rpn, ea[PG_BITS-1:0]};
    else             pa = '0;
  end
endmodule

// File: rtl/itlb_top.sv
module itlb_top #(
  parameter int EA_W    = 64,
  parameter int PA_W    = 56,
  parameter int PG_BITS = 12,
  parameter int IDX_W   = 6,
  parameter int NFOLD   = 3,
  localparam int TAG_W  = EA_W - PG_BITS,
  localparam int RPN_W  = PA_W - PG_BITS,
  localparam int HASH_W = IDX_W * NFOLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EA_W-1:0]   ea,
  input  logic              virt_mode,
  input  logic              priv_mode,
  input  logic              ld_en,
  input  logic [TAG_W-1:0]  ld_epn,
  input  logic [RPN_W-1:0]  ld_rpn,
  input  logic              ld_priv,
  input  logic              inv_en,
  input  logic              inv_all,
  input  logic [HASH_W-1:0] inv_vpn,
  output logic [PA_W-1:0]   pa,
  output logic              hit,
  output logic              fetch_failed
);
  logic [IDX_W-1:0] rd_idx, ld_idx, inv_idx;
  logic             st_vld, st_priv;
  logic [TAG_W-1:0] st_tag;
  logic [RPN_W-1:0] st_rpn;

  itlb_hash #(.IDX_W(IDX_W), .NFOLD(NFOLD)) u_hash_rd (
    .vpn_lo(ea[PG_BITS +: HASH_W]), .idx(rd_idx));
  itlb_hash #(.IDX_W(IDX_W), .NFOLD(NFOLD)) u_hash_ld (
    .vpn_lo(ld_epn[HASH_W-1:0]), .idx(ld_idx));
  itlb_hash #(.IDX_W(IDX_W), .NFOLD(NFOLD)) u_hash_inv (
    .vpn_lo(inv_vpn), .idx(inv_idx));

  itlb_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .RPN_W(RPN_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_epn), .ld_rpn(ld_rpn), .ld_priv(ld_priv),
    .inv_en(inv_en), .inv_idx(inv_idx), .inv_all(inv_all),
    .rd_vld(st_vld), .rd_tag(st_tag), .rd_rpn(st_rpn), .rd_priv(st_priv));

  itlb_check #(.EA_W(EA_W), .PA_W(PA_W), .PG_BITS(PG_BITS)) u_check (
    .ea(ea), .virt_mode(virt_mode), .priv_mode(priv_mode),
    .rd_vld(st_vld), .rd_tag(st_tag), .rd_rpn(st_rpn), .rd_priv(st_priv),
    .pa(pa), .hit(hit), .fetch_failed(fetch_failed));

  // R6: real mode passes the address through with no fault
  a_r6_real_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !virt_mode |-> (pa == ea[PA_W-1:0] && !hit && !fetch_failed));

  // R2: a reported hit always agrees with the stored valid bit and tag
  a_r2_hit_tag: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (st_vld && st_tag == ea[EA_W-1:PG_BITS]));

  // R5: user fetch of a privileged entry faults even when it hits
  a_r5_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && st_priv && !priv_mode) |-> fetch_failed);

  // R4: virtual-mode miss always faults
  a_r4_miss_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_mode && !hit) |-> (fetch_failed && pa == '0));
endmodule

// File: tb/itlb_top_tb_top.sv
`timescale 1ns/1ps
module itlb_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ea = '0;
  logic        virt_mode = 1'b0, priv_mode = 1'b0;
  logic        ld_en = 1'b0, ld_priv = 1'b0;
  logic [51:0] ld_epn = '0;
  logic [43:0] ld_rpn = '0;
  logic        inv_en = 1'b0, inv_all = 1'b0;
  logic [17:0] inv_vpn = '0;
  logic [55:0] pa;
  logic        hit, fetch_failed;

  int    n_vec = 0, n_bad = 0;
  bit    done = 0;
  string lbl = "R9";

  // behavioural model
  bit          m_vld  [64];
  logic [51:0] m_tag  [64];
  logic [43:0] m_rpn  [64];
  bit          m_priv [64];

  itlb_top dut_i (.*);

  always #5 clk = ~clk;

  function automatic int slot_of(logic [63:0] pn);
    return int'((pn ^ (pn >> 6) ^ (pn >> 12)) & 64'h3f);
  endfunction

  always @(negedge clk) begin
    int          s;
    bit          e_hit, e_fail;
    logic [55:0] e_pa;
    s      = slot_of(ea >> 12);
    e_hit  = virt_mode && rst_n && m_vld[s] && (m_tag[s] == ea[63:12]);
    if (!virt_mode)  e_pa = ea[55:0];
    else if (e_hit)  e_pa = {m_rpn[s], ea[11:0]};
    else             e_pa = '0;
    e_fail = virt_mode && (!e_hit || (m_priv[s] && !priv_mode));
    if (!rst_n) begin
      e_hit = 0; e_fail = virt_mode;
      if (virt_mode) e_pa = '0;
    end
    n_vec++;
    if (hit !== e_hit || fetch_failed !== e_fail || pa !== e_pa) begin
      n_bad++;
      $display("FAIL %s ea=%h: hit/ff/pa = %b/%b/%h expected %b/%b/%h",
               lbl, ea, hit, fetch_failed, pa, e_hit, e_fail, e_pa);
    end
    // model update for the coming edge
    if (!rst_n || inv_all) begin
      for (int i = 0; i < 64; i++) m_vld[i] = 0;
    end else begin
      if (inv_en) m_vld[slot_of({46'b0, inv_vpn})] = 0;
      if (ld_en) begin
        s = slot_of({12'b0, ld_epn});
        m_vld[s] = 1; m_tag[s] = ld_epn; m_rpn[s] = ld_rpn; m_priv[s] = ld_priv;
      end
    end
  end

  task automatic drive(string t, logic [63:0] a, bit v, bit p,
                       bit le, logic [51:0] lp, logic [43:0] lr, bit lpv,
                       bit ie, bit ia, logic [17:0] iv);
    @(posedge clk); #1;
    lbl = t; ea = a; virt_mode = v; priv_mode = p;
    ld_en = le; ld_epn = lp; ld_rpn = lr; ld_priv = lpv;
    inv_en = ie; inv_all = ia; inv_vpn = iv;
  endtask

  task automatic look(string t, logic [63:0] a, bit v, bit p);
    drive(t, a, v, p, 0, '0, '0, 0, 0, 0, '0);
  endtask

  task automatic load(string t, logic [63:0] a, logic [43:0] r, bit pv);
    drive(t, 64'h0, 0, 0, 1, a[63:12], r, pv, 0, 0, '0);
  endtask

  localparam logic [63:0] EA1  = 64'h0000_0012_3456_7ABC;
  localparam logic [63:0] EA1B = EA1 ^ (64'h15 << 12) ^ (64'h15 << 18); // same slot, new tag
  localparam logic [63:0] EA1C = EA1 ^ (64'h1 << 24);                   // different slot
  localparam logic [63:0] EA2  = 64'hFFFF_0000_0ACE_5123;

  initial begin
    for (int i = 0; i < 64; i++) begin m_vld[i] = 0; m_tag[i] = '0; m_rpn[i] = '0; m_priv[i] = 0; end
    look("R9", EA1, 1, 1);
    look("R9", EA1, 0, 1);
    #1 rst_n = 1'b1;
    look("R9", EA1, 1, 1);                        // empty table after reset
    look("R6", EA2, 0, 0);
    load("R3", EA1, 44'h0AB_CDEF_0123, 0);
    look("R3", EA1, 1, 0);
    look("R2", EA1B, 1, 0);                       // aliasing slot, tag mismatch
    look("R1", EA1C, 1, 0);                       // field change moves the slot
    load("R1", EA1C, 44'h111, 0);
    look("R1", EA1, 1, 1);
    look("R1", EA1C, 1, 1);
    look("R6", EA1, 0, 0);
    // R10: load and lookup to same slot in one cycle returns old data
    drive("R10", EA1B, 1, 1, 1, EA1B[63:12], 44'h222, 0, 0, 0, '0);
    look("R10", EA1B, 1, 1);
    look("R2", EA1, 1, 1);
    // R7: invalidate via another page number that folds to the same slot
    drive("R7", EA1B, 1, 1, 0, '0, '0, 0, 1, 0, EA1[29:12] ^ 18'h00555);
    look("R7", EA1B, 1, 1);
    look("R7", EA1C, 1, 1);
    // R5 privilege
    load("R5", EA2, 44'h0FE_DCBA_9876, 1);
    look("R5", EA2, 1, 0);
    look("R5", EA2, 1, 1);
    // R10: load beats single invalidate at the same slot
    drive("R10", EA2, 1, 1, 1, EA1[63:12], 44'h333, 0, 1, 0, EA1[29:12]);
    look("R10", EA1, 1, 1);
    // R8: flush drops a concurrent load
    drive("R8", EA1, 1, 1, 1, EA1B[63:12], 44'h444, 0, 0, 1, '0);
    look("R8", EA1B, 1, 1);
    look("R8", EA2, 1, 1);
    look("R8", EA1C, 1, 1);
    // random traffic over a small page pool
    for (int k = 0; k < 400; k++) begin
      logic [63:0] a, b;
      a = {32'h0000_00C0 + 32'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(0, 7)),
           6'($urandom_range(0, 3)), 6'($urandom_range(0, 3)), 12'($urandom)};
      b = {32'h0000_00C0 + 32'($urandom_range(0, 3)), 2'b0, 6'($urandom_range(0, 7)),
           6'($urandom_range(0, 3)), 6'($urandom_range(0, 3)), 12'h0};
      drive("R2", a, 1'($urandom_range(0, 4) != 0), 1'($urandom),
            1'($urandom_range(0, 2) == 0), b[63:12], 44'($urandom), 1'($urandom),
            1'($urandom_range(0, 7) == 0), 1'($urandom_range(0, 60) == 0),
            18'($urandom));
    end
    look("R6", EA2, 0, 1);
    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule